// File: doc/BRIEF.md
# Sprite Table Refresh Engine

This block keeps a 256-word on-chip sprite table in step with a copy that software maintains in video memory. Software writes the video-memory word address of that copy into a table-base register. The copy then starts at the next vertical-blank pulse. If the auto-refresh control bit is set, a copy also starts on every later vertical blank while the engine is idle. The table holds 64 sprites of four 16-bit words each. Within a sprite the words are, in ascending order, vertical position, horizontal position, pattern index and attributes.

The engine reads video memory through a request/grant port. It holds the request and the address steady until a grant arrives, and takes the read data in the granted cycle. Each word goes into the table write port one cycle later. When the last word is written, a completion status flag is raised. A host status read clears it. An interrupt line follows the flag when the interrupt-enable control bit is set.

Top module: `satb_dma`

## Requirements
- R1: After a synchronous reset, all of these are low: vram_req, tbl_we, done and irq. No copy is pending, and both control bits are clear.
- R2: A register write with reg_idx = 0x13 stores reg_wdata as the table base address and arms a single copy. The copy starts on the next vblank pulse seen while idle. Starting it consumes the arm, so a later vblank without auto-refresh starts nothing.
- R3: A copy reads 256 consecutive video-memory addresses, starting at the base and counting up modulo 2^16. vram_req stays high, and vram_addr stays unchanged, until vram_gnt is seen.
- R4: The data present on vram_rdata in a cycle with vram_req and vram_gnt both high is written one cycle later, with tbl_we high. The table index runs from 0 to 255 in read order, so index 4n+0 gets the vertical position of sprite n, 4n+1 its horizontal position, 4n+2 its pattern index and 4n+3 its attributes.
- R5: A register write with reg_idx = 0x0F sets the control word. Bit 4 enables auto-refresh: every vblank pulse seen while idle then starts a copy from the stored base.
- R6: A vblank pulse during a copy is ignored. It neither restarts the copy nor queues another one.
- R7: done (status bit 3) goes high in the same cycle as the final table write. It stays high until a stat_rd pulse clears it. If a copy completes in the same cycle as stat_rd, done is set.
- R8: irq is high exactly when done is high and control bit 0 is 1.
- R9: A vblank pulse with no armed copy and auto-refresh off starts no read.
- R10: Register writes to any index other than 0x13 and 0x0F change neither the base, the arm nor the control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_idx | input | 5 | Register index of the write |
| reg_wdata | input | 16 | Register write data |
| stat_rd | input | 1 | Status read pulse; clears done |
| vblank | input | 1 | One-cycle vertical blank pulse |
| vram_req | output | 1 | Video memory read request |
| vram_addr | output | 16 | Video memory word address |
| vram_gnt | input | 1 | Read grant; vram_rdata valid in this cycle |
| vram_rdata | input | 16 | Video memory read data |
| tbl_we | output | 1 | Sprite table write enable |
| tbl_addr | output | 8 | Sprite table word index |
| tbl_wdata | output | 16 | Sprite table write data |
| done | output | 1 | Copy-complete status flag |
| irq | output | 1 | Completion interrupt |

## Verification
The assertions assume that vblank lasts one cycle and that vram_gnt is honoured only while vram_req is high, with data valid in the same cycle. The bench drives vblank only as single-cycle pulses. Its memory model computes vram_rdata from vram_addr, so the data is valid whenever a grant arrives. Grants come either in a pseudo-random pattern or on every cycle, which exercises both the address hold and back-to-back copying. The stimulus includes a vblank during a copy, a base near the top of the address space, and writes to unrelated register indices.

// File: rtl/satb_pkg.sv
package satb_pkg;
  localparam int ADDR_W     = 16;
  localparam int DATA_W     = 16;
  localparam int IDX_W      = 5;
  localparam int SPRITES    = 64;
  localparam int WORDS_PER  = 4;
  localparam logic [IDX_W-1:0] IDX_TABLE = 5'h13;
  localparam logic [IDX_W-1:0] IDX_CTRL  = 5'h0F;
  localparam int CTRL_IRQ_BIT  = 0;
  localparam int CTRL_AUTO_BIT = 4;

  typedef struct packed {
    logic auto_en;
    logic irq_en;
  } ctrl_t;
endpackage

// File: rtl/satb_regs.sv
module satb_regs
  import satb_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [IW-1:0] idx,
  input  logic [AW-1:0] wdata,
  input  logic          stat_rd,
  input  logic          vblank,
  input  logic          busy,
  input  logic          last_beat,
  output logic          start_o,
  output logic [AW-1:0] base_o,
  output logic          done_o,
  output logic          irq_o
);
  ctrl_t ctrl_q, ctrl_n;
  logic  armed_q;
  logic  done_n;
  logic  tbl_wr, ctl_wr;

  assign tbl_wr  = wr && (idx == IDX_TABLE);
  assign ctl_wr  = wr && (idx == IDX_CTRL);
  assign start_o = vblank && !busy && (armed_q || ctrl_q.auto_en);

  always_comb begin
    ctrl_n = ctrl_q;
    if (ctl_wr) begin
      ctrl_n.auto_en = wdata[CTRL_AUTO_BIT];
      ctrl_n.irq_en  = wdata[CTRL_IRQ_BIT];
    end
    if (last_beat)    done_n = 1'b1;
    else if (stat_rd) done_n = 1'b0;
    else              done_n = done_o;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      armed_q <= 1'b0;
      base_o  <= '0;
      done_o  <= 1'b0;
      irq_o   <= 1'b0;
    end else begin
      ctrl_q <= ctrl_n;
      done_o <= done_n;
      irq_o  <= done_n && ctrl_n.irq_en;
      if (tbl_wr) begin
        base_o  <= wdata;
        armed_q <= 1'b1;
      end else if (start_o) begin
        armed_q <= 1'b0;
      end
    end
  end

  assert_irq_needs_done_R8: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> done_o);
  assert_done_from_last_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> $past(last_beat));
  assert_arm_consumed_R2: assert property (@(posedge clk) disable iff (rst)
    (start_o && !tbl_wr) |=> !armed_q);
endmodule

// File: rtl/satb_engine.sv
module satb_engine
  import satb_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W,
  parameter int WORDS = SPRITES * WORDS_PER,
  localparam int TW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [AW-1:0] base,
  input  logic          gnt,
  input  logic [DW-1:0] rd_data,
  output logic          req_o,
  output logic [AW-1:0] addr_o,
  output logic          last_o,
  output logic          we_o,
  output logic [TW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o
);
  logic [TW-1:0] cnt_q;
  logic          beat;

  assign beat   = req_o && gnt;
  assign last_o = beat && (cnt_q == TW'(WORDS - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      req_o   <= 1'b0;
      addr_o  <= '0;
      cnt_q   <= '0;
      we_o    <= 1'b0;
      waddr_o <= '0;
      wdata_o <= '0;
    end else begin
      we_o <= beat;
      if (beat) begin
        waddr_o <= cnt_q;
        wdata_o <= rd_data;
      end
      if (start) begin
        req_o  <= 1'b1;
        addr_o <= base;
        cnt_q  <= '0;
      end else if (last_o) begin
        req_o <= 1'b0;
      end else if (beat) begin
        addr_o <= addr_o + 1'b1;
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assert_addr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (req_o && !gnt) |=> (req_o && $stable(addr_o)));
  assert_write_after_grant_R4: assert property (@(posedge clk) disable iff (rst)
    we_o |-> $past(req_o && gnt));
  assert_vblank_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (req_o && !last_o) |=> req_o);
endmodule

// File: rtl/satb_dma.sv
module satb_dma
  import satb_pkg::*;
#(
  parameter int AW    = ADDR_W,
  parameter int DW    = DATA_W,
  parameter int IW    = IDX_W,
  parameter int WORDS = SPRITES * WORDS_PER,
  localparam int TW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr,
  input  logic [IW-1:0] reg_idx,
  input  logic [AW-1:0] reg_wdata,
  input  logic          stat_rd,
  input  logic          vblank,
  output logic          vram_req,
  output logic [AW-1:0] vram_addr,
  input  logic          vram_gnt,
  input  logic [DW-1:0] vram_rdata,
  output logic          tbl_we,
  output logic [TW-1:0] tbl_addr,
  output logic [DW-1:0] tbl_wdata,
  output logic          done,
  output logic          irq
);
  logic          start;
  logic          last_beat;
  logic [AW-1:0] base;

  satb_regs #(.AW(AW), .IW(IW)) u_regs (
    .clk(clk), .rst(rst), .wr(reg_wr), .idx(reg_idx), .wdata(reg_wdata),
    .stat_rd(stat_rd), .vblank(vblank), .busy(vram_req), .last_beat(last_beat),
    .start_o(start), .base_o(base), .done_o(done), .irq_o(irq)
  );

  satb_engine #(.AW(AW), .DW(DW), .WORDS(WORDS)) u_engine (
    .clk(clk), .rst(rst), .start(start), .base(base), .gnt(vram_gnt),
    .rd_data(vram_rdata), .req_o(vram_req), .addr_o(vram_addr),
    .last_o(last_beat), .we_o(tbl_we), .waddr_o(tbl_addr), .wdata_o(tbl_wdata)
  );
endmodule

// File: tb/test_satb_dma.sv
module test_satb_dma;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [4:0]  reg_idx = '0;
  logic [15:0] reg_wdata = '0;
  logic        stat_rd = 1'b0;
  logic        vblank = 1'b0;
  logic        vram_req;
  logic [15:0] vram_addr;
  logic        vram_gnt = 1'b0;
  logic [15:0] vram_rdata;
  logic        tbl_we;
  logic [7:0]  tbl_addr;
  logic [15:0] tbl_wdata;
  logic        done;
  logic        irq;

  int vectors = 0;
  int fails = 0;
  int gnt_mode = 0;

  always #5 clk = ~clk;

  function automatic logic [15:0] mem_f(input logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h5A3C;
  endfunction
  assign vram_rdata = mem_f(vram_addr);

  satb_dma i_satb_dma (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_idx(reg_idx), .reg_wdata(reg_wdata),
    .stat_rd(stat_rd), .vblank(vblank), .vram_req(vram_req), .vram_addr(vram_addr),
    .vram_gnt(vram_gnt), .vram_rdata(vram_rdata), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .done(done), .irq(irq)
  );

  // behavioural reference
  bit          m_go = 0;
  bit          m_armed, m_auto, m_ien, m_busy, m_done, m_irq, m_we;
  int          m_cnt, m_starts, m_writes;
  logic [15:0] m_base, m_addr, m_wdata;
  logic [7:0]  m_taddr;

  always @(posedge clk) begin
    bit fire, last, start;
    if (rst) begin
      m_armed = 0; m_auto = 0; m_ien = 0; m_busy = 0; m_done = 0; m_irq = 0;
      m_we = 0; m_cnt = 0; m_base = 0; m_addr = 0; m_wdata = 0; m_taddr = 0;
      m_starts = 0; m_writes = 0;
    end else begin
      fire  = m_busy && vram_gnt;
      last  = fire && (m_cnt == 255);
      start = vblank && !m_busy && (m_armed || m_auto);
      m_we = fire;
      if (fire) begin
        m_taddr = 8'(m_cnt); m_wdata = mem_f(m_addr); m_writes++;
      end
      if (start) begin
        m_busy = 1; m_cnt = 0; m_addr = m_base; m_starts++; m_armed = 0;
      end else if (last) m_busy = 0;
      else if (fire) begin
        m_cnt++; m_addr = m_addr + 16'd1;
      end
      if (last) m_done = 1;
      else if (stat_rd) m_done = 0;
      if (reg_wr && reg_idx == 5'h0F) begin
        m_auto = reg_wdata[4]; m_ien = reg_wdata[0];
      end
      if (reg_wr && reg_idx == 5'h13) begin
        m_base = reg_wdata; m_armed = 1;
      end
      m_irq = m_done && m_ien;
    end
    m_go = 1;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_go) begin
      chk(vram_req === m_busy, "R3 req", int'(vram_req), int'(m_busy));
      if (m_busy) chk(vram_addr === m_addr, "R3 addr", int'(vram_addr), int'(m_addr));
      chk(tbl_we === m_we, "R4 we", int'(tbl_we), int'(m_we));
      if (m_we) begin
        chk(tbl_addr === m_taddr, "R4 index", int'(tbl_addr), int'(m_taddr));
        chk(tbl_wdata === m_wdata, "R4 data", int'(tbl_wdata), int'(m_wdata));
      end
      chk(done === m_done, "R7 done", int'(done), int'(m_done));
      chk(irq === m_irq, "R8 irq", int'(irq), int'(m_irq));
    end
  end

  always @(posedge clk) begin
    #1;
    vram_gnt <= (gnt_mode == 1) ? 1'b1 : ($urandom_range(0, 3) != 0);
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wreg(input logic [4:0] i, input logic [15:0] d);
    reg_wr = 1; reg_idx = i; reg_wdata = d; tick(); reg_wr = 0;
  endtask

  task automatic pulse_vb();
    vblank = 1; tick(); vblank = 0;
  endtask

  task automatic run_xfer(input int inject_at);
    int w0;
    w0 = m_writes;
    pulse_vb();
    for (int n = 0; n < 4000; n++) begin
      vblank = (n == inject_at);
      tick();
      if (!m_busy) break;
    end
    vblank = 0;
    chk(m_writes - w0 == 256, "R4 word count", m_writes - w0, 256);
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    int s0;
    tick(); tick(); tick();
    rst = 0;
    tick();
    chk(vram_req == 0 && tbl_we == 0 && done == 0 && irq == 0, "R1 reset outputs",
        {vram_req, tbl_we, done, irq}, 0);
    // R9: nothing armed
    s0 = m_starts;
    pulse_vb(); tick(); tick();
    chk(vram_req == 0, "R9 idle vblank", int'(vram_req), 0);
    // R10: unrelated indices
    wreg(5'h12, 16'h4000);
    wreg(5'h0E, 16'h0011);
    pulse_vb(); tick(); tick();
    chk(vram_req == 0, "R10 other index", int'(vram_req), 0);
    // R2 one-shot with irq enabled, vblank injected mid-copy (R6)
    wreg(5'h0F, 16'h0001);
    wreg(5'h13, 16'h1200);
    s0 = m_starts;
    run_xfer(40);
    chk(m_starts - s0 == 1, "R6 single start", m_starts - s0, 1);
    tick();
    chk(vram_req == 0, "R6 no queued copy", int'(vram_req), 0);
    chk(done == 1, "R7 done set", int'(done), 1);
    chk(irq == 1, "R8 irq high", int'(irq), 1);
    stat_rd = 1; tick(); stat_rd = 0;
    chk(done == 0 && irq == 0, "R7 cleared by read", {done, irq}, 0);
    // R2: arm consumed
    pulse_vb(); tick(); tick();
    chk(vram_req == 0, "R2 arm consumed", int'(vram_req), 0);
    // R5 auto refresh, wrap base, irq off
    gnt_mode = 1;
    wreg(5'h0F, 16'h0010);
    wreg(5'h13, 16'hFFC0);
    run_xfer(-1);
    chk(done == 1 && irq == 0, "R8 irq masked", {done, irq}, 2);
    gnt_mode = 0;
    tick(); tick();
    s0 = m_starts;
    run_xfer(-1);
    chk(m_starts - s0 == 1, "R5 auto start", m_starts - s0, 1);
    // auto off
    wreg(5'h0F, 16'h0000);
    pulse_vb(); tick(); tick();
    chk(vram_req == 0, "R9 auto off", int'(vram_req), 0);
    tick();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule